// File: doc/BRIEF.md
# Bus fault status capture unit

This block records bus errors for an I/O bridge in a pair of 64-bit registers that software reads. One is a fault status word, the other is the full address of the faulting access. Three sources report errors: programmed I/O, DMA read and DMA write. Each source has its own one-cycle event strobe. All three share one set of transfer attributes: doubleword offset, log2 transfer size, master ID, ECC syndrome and address.

The first error that arrives while no primary cause is held becomes the primary fault. Its cause bit is set, and its attributes and address are frozen in the registers. An error that arrives while a primary cause is held only sets a sticky secondary cause bit, so the details of the first fault survive later overlapping faults. Software clears cause bits by writing ones to them.

A control register enables capture and the interrupt. The interrupt output stays high while any cause bit is set and the interrupt enable bit is set. The parameter `SYND_EN` selects the variant. With `SYND_EN` = 1 (the correctable-error variant) the syndrome is stored and control bit 61 enables the interrupt. With `SYND_EN` = 0 (the uncorrectable variant) no syndrome is stored and control bit 62 enables the interrupt.

Top module: `fault_capture`

## Requirements
- R1: While reset is held and after it is released, the status, fault address and control registers read zero and `irq` is low.
- R2: When an error event arrives and no primary cause is held, the primary bit for its source is set. The status bits for a PIO error, a DMA-read error and a DMA-write error are 63, 62 and 61. In the same cycle the doubleword offset is loaded into bits 47:45, the size into bits 44:42 and the master ID into bits 41:37. The address is loaded into the fault address register at byte offset 0x08.
- R3: When an error event arrives while a primary cause is held, only the matching secondary bit is set: 60 for PIO, 59 for DMA read, 58 for DMA write. The offset, size, ID, syndrome and address stay unchanged.
- R4: When several events arrive in the same cycle with no primary cause held, the source ranked highest becomes primary (PIO above DMA read, DMA read above DMA write). Every other source in that cycle sets its secondary bit. At most one primary bit is ever set.
- R5: A write to the status register at byte offset 0x00 clears each cause bit (63:58) written as 1 and leaves a bit written as 0 unchanged. Attribute fields ignore the write. Once all primary bits are cleared, the next event is captured as a new primary.
- R6: If an event and a write that clears the same cause bit happen in one cycle, the bit remains set. Primary state is judged after the clear, so an event that meets the clearing of the last primary bit is captured as a new primary with fresh attributes.
- R7: `irq` is high exactly when any cause bit is set and the interrupt enable control bit is set (bit 61 with `SYND_EN`=1). It stays high until every cause bit is cleared or the enable is cleared.
- R8: While the capture enable (control bit 63) is 0, error events change no status bit and no fault address bit.
- R9: With `SYND_EN`=1, the syndrome of the primary fault is stored in status bits 55:48. Bits 57:56 and 36:0 always read zero.
- R10: The control register at byte offset 0x10 stores bits 63:61 and reads zero elsewhere. Writes to the fault address register have no effect. Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pio | input | 1 | Programmed I/O error strobe |
| err_drd | input | 1 | DMA read error strobe |
| err_dwr | input | 1 | DMA write error strobe |
| err_doff | input | 3 | Doubleword offset of the faulting transfer |
| err_size | input | 3 | Transfer size as log2 of the byte count |
| err_mid | input | 5 | ID of the master that caused the fault |
| err_syn | input | 8 | ECC syndrome of the faulting data |
| err_addr | input | FADDR_W | Address of the faulting access |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte offset |
| wr_data | input | 64 | Register write data |
| rd_addr | input | ADDR_W | Register read byte offset |
| rd_data | output | 64 | Register read data (combinational) |
| irq | output | 1 | Fault interrupt |

## Verification
The capture path is tried with four kinds of input. A single event on an idle unit shows whether the primary fault loads correctly. Lone events arriving after a primary shows whether attributes are frozen or overwritten. Three-way and two-way simultaneous events show whether the priority ranking is right and whether losers are pushed to secondary. Writes that clear bits while an event arrives in the same cycle tell set-wins behaviour apart from clear-wins behaviour. They also show whether primary state is judged before or after the clear. Every status write also carries ones in the attribute field, so a writable attribute field shows up. Directed tests toggle the interrupt enable and the capture enable and clear the secondary bits last. These show that `irq` follows both the enable and all six bits.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
   localparam int NSRC     = 3;
   localparam int WORD_W   = 64;
   localparam int SRC_PIO  = 2;
   localparam int SRC_DRD  = 1;
   localparam int SRC_DWR  = 0;
   localparam int OFS_STAT = 'h00;
   localparam int OFS_FADR = 'h08;
   localparam int OFS_CTRL = 'h10;
   localparam int RSV_LO_W = 37;

   // packed in the order the status word places them, high to low
   typedef struct packed {
      logic [7:0] syn;
      logic [2:0] doff;
      logic [2:0] size;
      logic [4:0] mid;
   } attr_t;
endpackage

// File: rtl/fcap_arb.sv
module fcap_arb
   import fcap_pkg::*;
#(
   parameter int N = NSRC
) (
   input  logic [N-1:0] ev,
   input  logic         prim_busy,
   output logic [N-1:0] take_prim,
   output logic [N-1:0] take_sec,
   output logic         load
);
   logic seen;

   always_comb begin
      seen = 1'b0;
      take_prim = '0;
      for (int i = N - 1; i >= 0; i--) begin
         take_prim[i] = ev[i] & ~seen & ~prim_busy;
         seen = seen | ev[i];
      end
   end

   assign take_sec = ev & ~take_prim;
   assign load     = |take_prim;
endmodule

// File: rtl/fcap_cause.sv
module fcap_cause #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_prim,
   input  logic [N-1:0] set_sec,
   input  logic [N-1:0] clr_prim,
   input  logic [N-1:0] clr_sec,
   output logic [N-1:0] prim_q,
   output logic [N-1:0] sec_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prim_q <= '0;
         sec_q  <= '0;
      end else begin
         prim_q <= (prim_q & ~clr_prim) | set_prim;
         sec_q  <= (sec_q & ~clr_sec) | set_sec;
      end
   end
endmodule

// File: rtl/fcap_attr.sv
module fcap_attr
   import fcap_pkg::*;
#(
   parameter int FADDR_W = 64,
   parameter bit SYND_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  attr_t              attr_in,
   input  logic [FADDR_W-1:0] addr_in,
   output attr_t              attr_q,
   output logic [FADDR_W-1:0] addr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         attr_q.doff <= '0;
         attr_q.size <= '0;
         attr_q.mid  <= '0;
         addr_q      <= '0;
      end else if (load) begin
         attr_q.doff <= attr_in.doff;
         attr_q.size <= attr_in.size;
         attr_q.mid  <= attr_in.mid;
         addr_q      <= addr_in;
      end
   end

   if (SYND_EN) begin : g_syn
      always_ff @(posedge clk) begin
         if (!rst_n)    attr_q.syn <= '0;
         else if (load) attr_q.syn <= attr_in.syn;
      end
   end else begin : g_nosyn
      logic unused_syn;
      assign unused_syn = ^attr_in.syn;
      assign attr_q.syn = '0;
   end
endmodule

// File: rtl/fcap_regfile.sv
module fcap_regfile
   import fcap_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int FADDR_W = 64,
   parameter bit SYND_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [WORD_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   input  logic [NSRC-1:0]    prim_q,
   input  logic [NSRC-1:0]    sec_q,
   input  attr_t              attr_q,
   input  logic [FADDR_W-1:0] addr_q,
   output logic               stat_wr,
   output logic [NSRC-1:0]    clr_prim,
   output logic [NSRC-1:0]    clr_sec,
   output logic               chk_en,
   output logic               irq_en,
   output logic [WORD_W-1:0]  status_word,
   output logic [WORD_W-1:0]  faddr_word,
   output logic [WORD_W-1:0]  rd_data
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_FADR = ADDR_W'(OFS_FADR);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam int CTL_W = 3;

   logic [CTL_W-1:0] ctrl_q;
   logic             ctrl_wr;
   logic             unused_wdata;

   assign stat_wr  = wr_en && (wr_addr == A_STAT);
   assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
   assign clr_prim = stat_wr ? wr_data[WORD_W-1 -: NSRC] : '0;
   assign clr_sec  = stat_wr ? wr_data[WORD_W-1-NSRC -: NSRC] : '0;
   assign unused_wdata = ^wr_data[WORD_W-1-2*NSRC:0];

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= wr_data[WORD_W-1 -: CTL_W];
   end

   assign chk_en = ctrl_q[2];

   if (SYND_EN) begin : g_ce_irq
      assign irq_en = ctrl_q[0];
   end else begin : g_ue_irq
      assign irq_en = ctrl_q[1];
   end

   assign status_word = {prim_q, sec_q, 2'b00, attr_q, {RSV_LO_W{1'b0}}};
   assign faddr_word  = WORD_W'(addr_q);

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_STAT)      rd_data = status_word;
      else if (rd_addr == A_FADR) rd_data = faddr_word;
      else if (rd_addr == A_CTRL) rd_data = {ctrl_q, {(WORD_W-CTL_W){1'b0}}};
   end
endmodule

// File: rtl/fault_capture.sv
module fault_capture
   import fcap_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int FADDR_W = 64,
   parameter bit SYND_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               err_pio,
   input  logic               err_drd,
   input  logic               err_dwr,
   input  logic [2:0]         err_doff,
   input  logic [2:0]         err_size,
   input  logic [4:0]         err_mid,
   input  logic [7:0]         err_syn,
   input  logic [FADDR_W-1:0] err_addr,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [63:0]        wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [63:0]        rd_data,
   output logic               irq
);
   initial begin
      if (ADDR_W < 5)                  $fatal(1, "ADDR_W must cover offset 0x10");
      if (FADDR_W < 1 || FADDR_W > 64) $fatal(1, "FADDR_W must be 1..64");
   end

   logic [NSRC-1:0]    ev, prim_q, sec_q, clr_prim, clr_sec, take_prim, take_sec;
   logic               load, chk_en, irq_en, stat_wr, prim_busy;
   attr_t              attr_in, attr_q;
   logic [FADDR_W-1:0] addr_q;
   logic [63:0]        status_word, faddr_word;

   assign ev[SRC_PIO] = err_pio & chk_en;
   assign ev[SRC_DRD] = err_drd & chk_en;
   assign ev[SRC_DWR] = err_dwr & chk_en;
   assign prim_busy   = |(prim_q & ~clr_prim);
   assign attr_in     = '{syn: err_syn, doff: err_doff, size: err_size, mid: err_mid};

   fcap_arb #(.N(NSRC)) u_arb (
      .ev(ev), .prim_busy(prim_busy), .take_prim(take_prim),
      .take_sec(take_sec), .load(load)
   );

   fcap_cause #(.N(NSRC)) u_cause (
      .clk(clk), .rst_n(rst_n), .set_prim(take_prim), .set_sec(take_sec),
      .clr_prim(clr_prim), .clr_sec(clr_sec), .prim_q(prim_q), .sec_q(sec_q)
   );

   fcap_attr #(.FADDR_W(FADDR_W), .SYND_EN(SYND_EN)) u_attr (
      .clk(clk), .rst_n(rst_n), .load(load), .attr_in(attr_in),
      .addr_in(err_addr), .attr_q(attr_q), .addr_q(addr_q)
   );

   fcap_regfile #(.ADDR_W(ADDR_W), .FADDR_W(FADDR_W), .SYND_EN(SYND_EN)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .prim_q(prim_q), .sec_q(sec_q),
      .attr_q(attr_q), .addr_q(addr_q), .stat_wr(stat_wr),
      .clr_prim(clr_prim), .clr_sec(clr_sec), .chk_en(chk_en),
      .irq_en(irq_en), .status_word(status_word), .faddr_word(faddr_word),
      .rd_data(rd_data)
   );

   assign irq = irq_en & (|{prim_q, sec_q});
endmodule

// File: rtl/fcap_chk.sv
module fcap_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        pio_ev,
   input logic        chk_en,
   input logic        stat_wr,
   input logic        any_wr,
   input logic [5:0]  clr,
   input logic [63:0] status,
   input logic [63:0] faddr,
   input logic        irq
);
   AST_PRIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(status[63:61])); // R4

   AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((|status[63:61]) && !stat_wr) |=> ($stable(status[55:37]) && $stable(faddr))); // R3

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && pio_ev) |=> (status[63] || status[60])); // R6

   AST_W1C_PRIM: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && clr[5] && !(chk_en && pio_ev)) |=> !status[63]); // R5

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !any_wr) |=> irq); // R7

   AST_CHECK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_en && !stat_wr) |=> ($stable(status) && $stable(faddr))); // R8
endmodule

bind fault_capture fcap_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pio_ev(err_pio), .chk_en(chk_en),
   .stat_wr(stat_wr), .any_wr(wr_en), .clr(wr_data[63:58]),
   .status(status_word), .faddr(faddr_word), .irq(irq)
);

// File: tb/fault_capture_tb.sv
module fault_capture_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        err_pio = 0, err_drd = 0, err_dwr = 0;
   logic [2:0]  err_doff = 0, err_size = 0;
   logic [4:0]  err_mid = 0;
   logic [7:0]  err_syn = 0;
   logic [63:0] err_addr = 0;
   logic        wr_en = 0;
   logic [7:0]  wr_addr = 0, rd_addr = 0;
   logic [63:0] wr_data = 0;
   logic [63:0] rd_data;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   fault_capture u_dut (
      .clk(clk), .rst_n(rst_n), .err_pio(err_pio), .err_drd(err_drd),
      .err_dwr(err_dwr), .err_doff(err_doff), .err_size(err_size),
      .err_mid(err_mid), .err_syn(err_syn), .err_addr(err_addr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   function automatic logic [63:0] stw(input logic [2:0] p, input logic [2:0] s,
         input logic [7:0] syn, input logic [2:0] doff, input logic [2:0] size,
         input logic [4:0] mid);
      return {p, s, 2'b00, syn, doff, size, mid, 37'd0};
   endfunction

   typedef struct packed {
      logic [3:0]  req;
      logic [2:0]  ev;    // {pio, dma read, dma write}
      logic [2:0]  doff;
      logic [2:0]  size;
      logic [4:0]  mid;
      logic [7:0]  syn;
      logic [15:0] adr;
      logic [5:0]  clr;   // status bits 63..58
      logic [63:0] xs;
      logic [15:0] xa;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      // R2, R9: first DMA read error
      '{4'd2, 3'b010, 3'd5, 3'd3, 5'h11, 8'hA5, 16'h1234, 6'b000000, stw(3'b010,3'b000,8'hA5,3'd5,3'd3,5'h11), 16'h1234},
      // R3: later PIO only secondary
      '{4'd3, 3'b100, 3'd1, 3'd1, 5'h02, 8'h33, 16'h5555, 6'b000000, stw(3'b010,3'b100,8'hA5,3'd5,3'd3,5'h11), 16'h1234},
      // R3: later DMA write only secondary
      '{4'd3, 3'b001, 3'd7, 3'd7, 5'h1F, 8'hFF, 16'h9999, 6'b000000, stw(3'b010,3'b101,8'hA5,3'd5,3'd3,5'h11), 16'h1234},
      // R5: clear secondary PIO only
      '{4'd5, 3'b000, 3'd0, 3'd0, 5'h00, 8'h00, 16'h0000, 6'b000100, stw(3'b010,3'b001,8'hA5,3'd5,3'd3,5'h11), 16'h1234},
      // R5: clear primary, attributes kept
      '{4'd5, 3'b000, 3'd0, 3'd0, 5'h00, 8'h00, 16'h0000, 6'b010000, stw(3'b000,3'b001,8'hA5,3'd5,3'd3,5'h11), 16'h1234},
      // R4: all three at once, PIO wins
      '{4'd4, 3'b111, 3'd2, 3'd6, 5'h0A, 8'h0F, 16'hBEEF, 6'b000000, stw(3'b100,3'b011,8'h0F,3'd2,3'd6,5'h0A), 16'hBEEF},
      // R5: clear all
      '{4'd5, 3'b000, 3'd0, 3'd0, 5'h00, 8'h00, 16'h0000, 6'b111111, stw(3'b000,3'b000,8'h0F,3'd2,3'd6,5'h0A), 16'hBEEF},
      // R4: read and write at once, read wins
      '{4'd4, 3'b011, 3'd7, 3'd0, 5'h03, 8'hFF, 16'h0042, 6'b000000, stw(3'b010,3'b001,8'hFF,3'd7,3'd0,5'h03), 16'h0042},
      // R6: clear of secondary write meets a new write error
      '{4'd6, 3'b001, 3'd1, 3'd1, 5'h01, 8'h11, 16'h0101, 6'b000001, stw(3'b010,3'b001,8'hFF,3'd7,3'd0,5'h03), 16'h0042},
      // R5: clear all
      '{4'd5, 3'b000, 3'd0, 3'd0, 5'h00, 8'h00, 16'h0000, 6'b111111, stw(3'b000,3'b000,8'hFF,3'd7,3'd0,5'h03), 16'h0042},
      // R2: fresh primary DMA write
      '{4'd2, 3'b001, 3'd3, 3'd2, 5'h04, 8'h5A, 16'h0777, 6'b000000, stw(3'b001,3'b000,8'h5A,3'd3,3'd2,5'h04), 16'h0777},
      // R6: clear of last primary meets new write error: new primary
      '{4'd6, 3'b001, 3'd6, 3'd5, 5'h09, 8'h77, 16'h0888, 6'b001000, stw(3'b001,3'b000,8'h77,3'd6,3'd5,5'h09), 16'h0888},
      // R3: PIO after that is secondary
      '{4'd3, 3'b100, 3'd0, 3'd0, 5'h00, 8'h00, 16'h0000, 6'b000000, stw(3'b001,3'b100,8'h77,3'd6,3'd5,5'h09), 16'h0888}
   };

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [63:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic wreg(input logic [7:0] a, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0; wr_data = 0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      // R1: during and after reset
      repeat (2) @(negedge clk);
      rd(8'h00, d); check("R1 status in reset", d, 64'h0);
      check("R1 irq in reset", {63'd0, irq}, 64'h0);
      rst_n = 1;
      @(negedge clk);
      rd(8'h00, d); check("R1 status", d, 64'h0);
      rd(8'h08, d); check("R1 address", d, 64'h0);
      rd(8'h10, d); check("R1 control", d, 64'h0);

      wreg(8'h10, 64'hE000_0000_0000_0000);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {err_pio, err_drd, err_dwr} = VEC[i].ev;
         err_doff = VEC[i].doff; err_size = VEC[i].size; err_mid = VEC[i].mid;
         err_syn  = VEC[i].syn;  err_addr = 64'(VEC[i].adr);
         wr_en = 1; wr_addr = 8'h00; wr_data = {VEC[i].clr, {58{1'b1}}};
         @(negedge clk);
         {err_pio, err_drd, err_dwr} = 3'b000;
         wr_en = 0; wr_data = 0;
         rd(8'h00, d);
         check($sformatf("R%0d vector %0d status", VEC[i].req, i), d, VEC[i].xs);
         rd(8'h08, d);
         check($sformatf("R%0d vector %0d address", VEC[i].req, i), d, 64'(VEC[i].xa));
      end

      // R7: interrupt follows causes and enable
      check("R7 irq with causes", {63'd0, irq}, 64'h1);
      wreg(8'h10, 64'h8000_0000_0000_0000);
      check("R7 irq enable off", {63'd0, irq}, 64'h0);
      wreg(8'h10, 64'hE000_0000_0000_0000);
      wreg(8'h00, 64'h2000_0000_0000_0000);
      check("R7 irq held by secondary", {63'd0, irq}, 64'h1);
      wreg(8'h00, 64'h1000_0000_0000_0000);
      check("R7 irq all clear", {63'd0, irq}, 64'h0);

      // R8: capture disabled
      wreg(8'h10, 64'h6000_0000_0000_0000);
      @(negedge clk);
      err_pio = 1; err_dwr = 1; err_addr = 64'hDEAD; err_mid = 5'h1E;
      @(negedge clk);
      err_pio = 0; err_dwr = 0;
      rd(8'h00, d); check("R8 status unchanged", d, stw(3'b000,3'b000,8'h77,3'd6,3'd5,5'h09));
      rd(8'h08, d); check("R8 address unchanged", d, 64'h0888);
      check("R8 irq low", {63'd0, irq}, 64'h0);

      // R10: control field, address read-only, unmapped
      rd(8'h10, d); check("R10 control readback", d, 64'h6000_0000_0000_0000);
      wreg(8'h10, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(8'h10, d); check("R10 control upper bits only", d, 64'hE000_0000_0000_0000);
      wreg(8'h08, 64'h1234_5678_9ABC_DEF0);
      rd(8'h08, d); check("R10 address write ignored", d, 64'h0888);
      rd(8'h18, d); check("R10 unmapped read", d, 64'h0);

      // R1: reset mid-run
      @(negedge clk); err_drd = 1;
      @(negedge clk); err_drd = 0;
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      rd(8'h00, d); check("R1 status after rerun reset", d, 64'h0);
      rd(8'h08, d); check("R1 address after rerun reset", d, 64'h0);
      rd(8'h10, d); check("R1 control after rerun reset", d, 64'h0);
      check("R1 irq after rerun reset", {63'd0, irq}, 64'h0);

      done = 1;
      summary();
      $finish;
   end
endmodule